// File: doc/BRIEF.md
# Dual-Compare Interval Timer

This block is a 16-bit interval timer. Software programs it through a four-word register port. The counter advances by one on each cycle in which the `tick` clock-enable is high and the timer is running. On each count it compares the next value against the active limit. The active limit is limit A in single mode. In alternate mode the timer switches between limit A and limit B, so one full cycle is made of two phases of different lengths.

Each limit match resets the count to zero and sets a sticky match flag. When requests are enabled, a match also raises a one-cycle interrupt request. The run bit is guarded: a control write changes it only when that same write also carries the unlock bit. A running-mode bit chooses what happens at the end of a full cycle:

- With the bit set, the timer keeps counting.
- With the bit clear, hardware stops the timer.

Run and limit selection are held in a four-state machine:

- `ST_HALT_A` and `ST_HALT_B` are the stopped states, with limit A or limit B selected.
- `ST_RUN_A` and `ST_RUN_B` are the counting states, with limit A or limit B selected.

The hardware transitions are:

- **A-match advance:** `ST_RUN_A` goes to `ST_RUN_B` on a match in alternate mode.
- **End-of-cycle wrap:** `ST_RUN_A` (single mode) or `ST_RUN_B` goes to `ST_RUN_A` on a match when continuous mode is set.
- **End-of-cycle stop:** the same match goes to `ST_HALT_A` when continuous mode is clear.

A control write then overrides the result:

- **Unlock write:** the run half of the state takes the written run bit.
- **Single-mode write:** the selection half returns to A.

Top module: `dct_timer`

## Requirements
- R1: After reset the count, both limits and the control word read 0, the timer is stopped, and `irq` is low.
- R2: The register map is: address 0 is the control word, 1 is the count, 2 is limit A and 3 is limit B; all four can be read, and all but the control word's status bits can be written. A write to the count loads it, and any tick in that same cycle is dropped.
- R3: Control bit 0 (run) changes on a control write only when bit 1 (unlock) of that same write is 1; otherwise the written run value is ignored.
- R4: Control bit 1 (unlock) and control bits 7 to 15 always read 0.
- R5: When control bit 2 (request enable) is 1, `irq` is high for exactly the one cycle after each match; when that bit is 0, `irq` stays low.
- R6: Control bit 4 (read-only) reads 1 while limit B is active and 0 while limit A is active. While control bit 3 (alternate) is 0, only limit A is used, and a control write with bit 3 clear forces bit 4 to 0.
- R7: Control bit 5 is set by a match and is never cleared by hardware. A control write with bit 5 = 0 clears it, but a match in the same cycle leaves it set.
- R8: In alternate mode, a match on the active limit resets the count to 0 and toggles control bit 4.
- R9: With control bit 6 (continuous) set to 1, the timer keeps running after matches. With it at 0, run is cleared at the match that ends a cycle: a limit-A match in single mode, or a limit-B match in alternate mode.
- R10: While running, the count rises by 1 per tick, and a limit of N gives a period of N ticks (count 0 to N-1). A limit of 0 gives a period of 65536 ticks. While stopped, ticks leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable; one count per high cycle |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The bench uses the default width of 16 bits, so the limit-of-zero case runs a full 65536-tick period. This shows the wrap from 0xFFFF to 0 and the stop that follows it. Small limits of 1 to 5 bring the other corner cases within a few cycles:

- a match on every tick;
- a flag clear in the same cycle as a match;
- the A-to-B alternation;
- the two end-of-cycle stop points.

// File: rtl/dct_pkg.sv
package dct_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADR_CTL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_CNT  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_LIMA = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_LIMB = 2'd3;

    localparam int B_RUN  = 0;
    localparam int B_KEY  = 1;
    localparam int B_IRQE = 2;
    localparam int B_ALT  = 3;
    localparam int B_SEL  = 4;
    localparam int B_HIT  = 5;
    localparam int B_CONT = 6;
    localparam int CTL_USED = 7;

    // bit 0 = running, bit 1 = limit B selected
    typedef enum logic [1:0] {
        ST_HALT_A = 2'b00,
        ST_RUN_A  = 2'b01,
        ST_HALT_B = 2'b10,
        ST_RUN_B  = 2'b11
    } dct_state_e;
endpackage

// File: rtl/dct_limits.sv
module dct_limits #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   wr_vec,
    input  logic [W-1:0] wdata,
    input  logic         sel_b,
    output logic [W-1:0] lim_a,
    output logic [W-1:0] lim_b,
    output logic [W-1:0] active
);
    localparam int NLIM = 2;
    logic [W-1:0] lim_q [NLIM];

    for (genvar g = 0; g < NLIM; g++) begin : g_lim
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lim_q[g] <= '0;
            else if (wr_vec[g])
                lim_q[g] <= wdata;
        end
    end

    assign lim_a  = lim_q[0];
    assign lim_b  = lim_q[1];
    assign active = sel_b ? lim_q[1] : lim_q[0];
endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         match
);
    logic [W-1:0] nxt;

    // a limit of 0 matches after the wrap, giving 2**W ticks
    assign nxt   = count + W'(1);
    assign match = step && !ld && (nxt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (ld)
            count <= ld_val;
        else if (match)
            count <= '0;
        else if (step)
            count <= nxt;
    end

    // R10: no tick and no load keeps the count
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !ld) |=> $stable(count));
    // R8: a match returns the count to zero
    a_r8_match_zero: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (count == '0));
endmodule

// File: rtl/dct_fsm.sv
module dct_fsm
    import dct_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic alt,
    input  logic cont,
    input  logic ctl_wr,
    input  logic wr_key,
    input  logic wr_run,
    input  logic wr_alt,
    output logic run,
    output logic sel_b
);
    dct_state_e state, state_hw, state_n;
    logic run_n, sel_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_HALT_A;
        else
            state <= state_n;
    end

    always_comb begin
        state_hw = state;
        unique case (state)
            ST_HALT_A, ST_HALT_B: state_hw = state;
            ST_RUN_A: if (match)
                state_hw = alt ? ST_RUN_B : (cont ? ST_RUN_A : ST_HALT_A);
            ST_RUN_B: if (match)
                state_hw = cont ? ST_RUN_A : ST_HALT_A;
            default: state_hw = ST_HALT_A;
        endcase
        run_n   = state_hw[0];
        sel_n   = state_hw[1];
        state_n = state_hw;
        if (ctl_wr) begin
            run_n   = wr_key ? wr_run : state_hw[0];
            sel_n   = wr_alt & state_hw[1];
            state_n = dct_state_e'({sel_n, run_n});
        end
    end

    always_comb begin
        run   = state[0];
        sel_b = state[1];
    end

    a_r3_locked_run: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wr_key && !match) |=> (run == $past(run)));
    a_r6_single_uses_a: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wr_alt) |=> !sel_b);
    a_r8_alt_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (match && alt && !ctl_wr) |=> (sel_b != $past(sel_b)));
    a_r9_cycle_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !cont && (!alt || sel_b) && !ctl_wr) |=> !run);
endmodule

// File: rtl/dct_timer.sv
module dct_timer
    import dct_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         bus_wr,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    output logic         irq
);
    logic         ctl_wr, cnt_wr;
    logic [1:0]   lim_wr;
    logic         run, sel_b, match;
    logic         irqe_q, alt_q, cont_q, hit_q;
    logic [W-1:0] count, lim_a, lim_b, limit;

    assign ctl_wr = bus_wr && (bus_addr == ADR_CTL);
    assign cnt_wr = bus_wr && (bus_addr == ADR_CNT);
    assign lim_wr = {bus_wr && (bus_addr == ADR_LIMB), bus_wr && (bus_addr == ADR_LIMA)};

    dct_limits #(.W(W)) u_limits (
        .clk(clk), .rst_n(rst_n), .wr_vec(lim_wr), .wdata(bus_wdata),
        .sel_b(sel_b), .lim_a(lim_a), .lim_b(lim_b), .active(limit)
    );

    dct_counter #(.W(W)) u_counter (
        .clk(clk), .rst_n(rst_n), .step(tick && run), .ld(cnt_wr),
        .ld_val(bus_wdata), .limit(limit), .count(count), .match(match)
    );

    dct_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .match(match), .alt(alt_q), .cont(cont_q),
        .ctl_wr(ctl_wr), .wr_key(bus_wdata[B_KEY]), .wr_run(bus_wdata[B_RUN]),
        .wr_alt(bus_wdata[B_ALT]), .run(run), .sel_b(sel_b)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irqe_q <= 1'b0;
            alt_q  <= 1'b0;
            cont_q <= 1'b0;
            hit_q  <= 1'b0;
            irq    <= 1'b0;
        end else begin
            if (ctl_wr) begin
                irqe_q <= bus_wdata[B_IRQE];
                alt_q  <= bus_wdata[B_ALT];
                cont_q <= bus_wdata[B_CONT];
            end
            hit_q <= match || (hit_q && !(ctl_wr && !bus_wdata[B_HIT]));
            irq   <= match && irqe_q;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADR_CTL:  bus_rdata = {{(W-CTL_USED){1'b0}}, cont_q, hit_q, sel_b,
                                   alt_q, irqe_q, 1'b0, run};
            ADR_CNT:  bus_rdata = count;
            ADR_LIMA: bus_rdata = lim_a;
            default:  bus_rdata = lim_b;
        endcase
    end

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_q && !(ctl_wr && !bus_wdata[B_HIT])) |=> hit_q);
    a_r5_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> hit_q);
endmodule

// File: tb/dct_timer_tb.sv
`timescale 1ns/1ps
module dct_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dct_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    localparam logic [1:0] A_CTL = 2'd0, A_CNT = 2'd1, A_LA = 2'd2, A_LB = 2'd3;

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a; #0.5; d = bus_rdata;
    endtask

    task automatic run_ticks(input int n);
        tick = 1'b1;
        repeat (n) begin @(posedge clk); @(negedge clk); end
        tick = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v); chk("R1", "reg after reset", v, 16'h0000);
        end
        chk("R1", "irq after reset", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_unlock;
        logic [15:0] v;
        wr(A_CTL, 16'h0001);
        rd(A_CTL, v); chk("R3", "run without unlock", v, 16'h0000);
        run_ticks(3);
        rd(A_CNT, v); chk("R10", "stopped count", v, 16'h0000);
        wr(A_CTL, 16'hFF83);
        rd(A_CTL, v); chk("R4", "unlock and reserved read 0", v, 16'h0001);
    endtask

    task automatic t_irq_single;
        logic [15:0] v;
        wr(A_LA, 16'd4); wr(A_CNT, 16'd0); wr(A_CTL, 16'h0047);
        rd(A_CTL, v); chk("R4", "ctl readback", v, 16'h0045);
        tick = 1'b1;
        for (int i = 1; i <= 8; i++) begin
            @(posedge clk); @(negedge clk);
            chk("R5", "irq pulse", {15'd0, irq}, {15'd0, (i % 4 == 0)});
            rd(A_CNT, v); chk("R10", "count step", v, 16'(i % 4));
        end
        tick = 1'b0;
        rd(A_CTL, v); chk("R7", "flag set", v, 16'h0065);
        wr(A_CTL, 16'h0043);
        rd(A_CTL, v); chk("R7", "flag cleared by write", v, 16'h0041);
        tick = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            @(posedge clk); @(negedge clk);
            chk("R5", "irq disabled", {15'd0, irq}, 16'h0000);
        end
        tick = 1'b0;
        rd(A_CTL, v); chk("R7", "flag without irq", v, 16'h0061);
    endtask

    task automatic t_flag_race;
        logic [15:0] v;
        wr(A_LA, 16'd1); wr(A_CNT, 16'd0); wr(A_CTL, 16'h0043);
        rd(A_CTL, v); chk("R7", "setup", v, 16'h0041);
        tick = 1'b1;
        wr(A_CTL, 16'h0041);
        tick = 1'b0;
        rd(A_CTL, v); chk("R7", "match beats clear", v, 16'h0061);
        wr(A_CTL, 16'h0041);
        rd(A_CTL, v); chk("R7", "clear alone", v, 16'h0041);
    endtask

    task automatic t_single_stop;
        logic [15:0] v;
        wr(A_LA, 16'd3); wr(A_CNT, 16'd0); wr(A_CTL, 16'h0003);
        rd(A_CTL, v); chk("R9", "setup", v, 16'h0001);
        run_ticks(2);
        rd(A_CTL, v); chk("R9", "still running", v, 16'h0001);
        run_ticks(1);
        rd(A_CTL, v); chk("R9", "stopped at A", v, 16'h0020);
        rd(A_CNT, v); chk("R10", "count after stop", v, 16'h0000);
        run_ticks(2);
        rd(A_CNT, v); chk("R10", "ticks ignored when stopped", v, 16'h0000);
    endtask

    task automatic t_alt_cont;
        logic [15:0] v;
        logic [15:0] ec [5] = '{16'd1, 16'd0, 16'd1, 16'd2, 16'd0};
        logic        es [5] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
        wr(A_LA, 16'd2); wr(A_LB, 16'd3); wr(A_CNT, 16'd0); wr(A_CTL, 16'h004B);
        rd(A_CTL, v); chk("R6", "setup", v, 16'h0049);
        tick = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); @(negedge clk);
            rd(A_CNT, v); chk("R8", "alt count", v, ec[i]);
            rd(A_CTL, v); chk("R6", "limit select", {15'd0, v[4]}, {15'd0, es[i]});
            chk("R9", "continuous run", {15'd0, v[0]}, 16'h0001);
        end
        tick = 1'b0;
    endtask

    task automatic t_alt_stop;
        logic [15:0] v;
        wr(A_CNT, 16'd0); wr(A_CTL, 16'h000B);
        run_ticks(2);
        rd(A_CTL, v); chk("R9", "runs past A match", v, 16'h0039);
        run_ticks(3);
        rd(A_CTL, v); chk("R9", "stops after B match", v, 16'h0028);
    endtask

    task automatic t_force_single;
        logic [15:0] v;
        wr(A_LA, 16'd1); wr(A_LB, 16'd5); wr(A_CNT, 16'd0); wr(A_CTL, 16'h004B);
        run_ticks(1);
        rd(A_CTL, v); chk("R8", "B selected", v, 16'h0079);
        wr(A_CTL, 16'h0041);
        rd(A_CTL, v); chk("R6", "single forces A", v, 16'h0041);
    endtask

    task automatic t_full_period;
        logic [15:0] v;
        wr(A_LA, 16'd0); wr(A_CNT, 16'd0); wr(A_CTL, 16'h0003);
        run_ticks(65535);
        rd(A_CNT, v); chk("R10", "count before wrap", v, 16'hFFFF);
        rd(A_CTL, v); chk("R10", "running before wrap", v, 16'h0001);
        run_ticks(1);
        rd(A_CNT, v); chk("R10", "wrap to 0", v, 16'h0000);
        rd(A_CTL, v); chk("R10", "match at 65536", v, 16'h0020);
    endtask

    task automatic t_load;
        logic [15:0] v;
        wr(A_LA, 16'd100); wr(A_CTL, 16'h0043);
        tick = 1'b1;
        wr(A_CNT, 16'd50);
        tick = 1'b0;
        rd(A_CNT, v); chk("R2", "load drops tick", v, 16'd50);
        run_ticks(1);
        rd(A_CNT, v); chk("R2", "counts from load", v, 16'd51);
        rd(A_LA, v); chk("R2", "limit A readback", v, 16'd100);
        rd(A_LB, v); chk("R2", "limit B readback", v, 16'd5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_unlock;
        t_irq_single;
        t_flag_race;
        t_single_stop;
        t_alt_cont;
        t_alt_stop;
        t_force_single;
        t_full_period;
        t_load;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule